// File: doc/BRIEF.md
# Host Wake Power Handshake Controller

This block sits between a host register port and a power-gated internal core. The host sets an init-done bit to bring the core to full power and an access-request bit to keep it awake while it touches internal resources. A sequencer turns the core's power domain on and off. It waits on a power acknowledge input that models the analog switch. It reports clock-ready, going-to-sleep and a 3-bit power-save type back through the control register.

The core may ask to sleep. The request is refused while the host holds its access request. Without that request, the core goes down once it has asked for sleep for a set number of consecutive cycles. A grant output tells the host when internal access is safe. A synchronised RF-kill switch is mirrored into the control register, and every toggle of the switch latches a pending interrupt. A separate reset register carries a bus-master stop request, its disabled status and a self-clearing software reset.

Registers sit at word addresses 0 (control), 1 (reset) and 2 (interrupt). A write takes effect on the clock edge that samples it. Read data is registered and shows the addressed register one cycle after the address is presented.

Top module: `pwr_wake_ctrl`

## Requirements
- R1: After reset, the control register (address 0) reads all zero, and `pwr_on` and `host_grant` are 0.
- R2: While init-done (control bit 2) is 0, the power domain stays off and clock-ready (control bit 0) stays 0, even when access-request (control bit 3) is set.
- R3: Setting init-done raises `pwr_on`. Once `pwr_ack` is seen, clock-ready reads 1, going-to-sleep (control bit 4) reads 0 and the power-save type (control bits 26:24) reads 000.
- R4: `host_grant` is 1 only while access-request is set, clock-ready is 1 and going-to-sleep is 0.
- R5: While access-request is held, an asserted `core_sleep_req` never takes the core out of the ready state.
- R6: With access-request clear, the core leaves the ready state only after `core_sleep_req` has been high for IDLE_CYCLES consecutive cycles. During the power-down, going-to-sleep reads 1, clock-ready reads 0 and `pwr_on` is 0.
- R7: Once the power-down completes with init-done still set, the power-save type reads 001 (MAC power-down). Setting access-request wakes the core back to clock-ready with type 000.
- R8: Control bit 27 follows the synchronised `rfkill_sw` input. While the core is ready and the switch is active, the power-save type reads 010 (PHY power-down).
- R9: Every change of the synchronised switch sets the pending bit 7 of the interrupt register (address 2), which drives `rfkill_irq`.
- R10: Writing 1 to interrupt bit 7 clears the pending bit. Writing 0 there leaves it set.
- R11: If `pwr_ack` drops while the core is ready, the power-save type reads 011 (error), clock-ready reads 0, and `pwr_on` and `host_grant` go to 0.
- R12: Writing 1 to reset-register (address 1) bit 9 sets `mstr_halt`. Bit 8 of that register reads 1 from the following cycle.
- R13: Writing 1 to reset-register bit 7 issues a software reset that clears itself and returns every register and the sequencer to the reset state. Bit 7 always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register word address (0 control, 1 reset, 2 interrupt) |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Registered read data for the address of the previous cycle |
| core_sleep_req | input | 1 | Sleep request from the internal core |
| pwr_ack | input | 1 | Power switch acknowledge (high when the domain is powered) |
| rfkill_sw | input | 1 | Asynchronous RF-kill switch level |
| pwr_on | output | 1 | Power domain enable |
| host_grant | output | 1 | Host may access internal resources |
| rfkill_irq | output | 1 | RF-kill toggle interrupt pending |
| mstr_halt | output | 1 | Bus mastering stop request |

## Verification
The wake sequence is run three ways, and each run separates a different part of the gating. The first sets access-request alone, so init-done is shown to be the real power gate. The second keeps access held against a standing core sleep request, so refusal is told apart from plain idle timing. The third releases access and reads the ready state a few cycles before the idle limit, then polls for the drain and doze phases, so an early or skipped power-down shows up. The RF-kill switch is toggled both ways, with a write of 0 and a write of 1 to the pending bit in between. A power acknowledge dropped while the core is ready, and a software reset issued with the sequencer in its fault state, show the error encoding and a complete return to reset values.

// File: rtl/pwr_wake_pkg.sv
package pwr_wake_pkg;

  // register word addresses
  localparam int unsigned ADDR_CTRL = 0;
  localparam int unsigned ADDR_RST  = 1;
  localparam int unsigned ADDR_IRQ  = 2;

  // control register bits
  localparam int unsigned B_CLK_RDY  = 0;
  localparam int unsigned B_INIT     = 2;
  localparam int unsigned B_ACC      = 3;
  localparam int unsigned B_SLEEPING = 4;
  localparam int unsigned B_PS_LO    = 24;
  localparam int unsigned B_RFKILL   = 27;

  // reset register bits
  localparam int unsigned B_SWRST = 7;
  localparam int unsigned B_MDIS  = 8;
  localparam int unsigned B_MSTOP = 9;

  // interrupt register bit
  localparam int unsigned B_RFK_IRQ = 7;

  localparam int unsigned PS_W = 3;
  localparam logic [PS_W-1:0] PS_NONE = 3'b000;
  localparam logic [PS_W-1:0] PS_MAC  = 3'b001;
  localparam logic [PS_W-1:0] PS_PHY  = 3'b010;
  localparam logic [PS_W-1:0] PS_ERR  = 3'b011;

  typedef enum logic [2:0] {
    ST_OFF   = 3'd0,
    ST_WAKE  = 3'd1,
    ST_RUN   = 3'd2,
    ST_DRAIN = 3'd3,
    ST_DOZE  = 3'd4,
    ST_FAULT = 3'd5
  } pwr_state_e;

endpackage

// File: rtl/pwr_rfkill_mon.sv
module pwr_rfkill_mon #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic rfkill_sw,
  input  logic irq_clr,
  output logic rf_state,
  output logic irq_pend
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   toggle;

  always_ff @(posedge clk) begin
    if (rst) sync_q[0] <= 1'b0;
    else     sync_q[0] <= rfkill_sw;
  end

  for (genvar i = 1; i < SYNC_STAGES; i++) begin : g_sync
    always_ff @(posedge clk) begin
      if (rst) sync_q[i] <= 1'b0;
      else     sync_q[i] <= sync_q[i-1];
    end
  end

  assign rf_state = sync_q[SYNC_STAGES-1];
  assign toggle   = rf_state ^ prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q   <= 1'b0;
      irq_pend <= 1'b0;
    end else begin
      prev_q <= rf_state;
      if (toggle)       irq_pend <= 1'b1;
      else if (irq_clr) irq_pend <= 1'b0;
    end
  end

  // R9
  rfk_toggle_sets_chk: assert property (@(posedge clk) disable iff (rst)
    (rf_state != prev_q) |=> irq_pend);

  // R10
  rfk_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_clr && irq_pend && (rf_state == prev_q)) |=> !irq_pend);

endmodule

// File: rtl/pwr_wake_fsm.sv
module pwr_wake_fsm
  import pwr_wake_pkg::*;
#(
  parameter int unsigned IDLE_CYCLES = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            init_done,
  input  logic            access_req,
  input  logic            core_sleep_req,
  input  logic            pwr_ack,
  input  logic            rf_kill,
  output pwr_state_e      state_q,
  output pwr_state_e      state_nx,
  output logic            clk_ready,
  output logic            going_sleep,
  output logic            pwr_on,
  output logic [PS_W-1:0] ps_type
);

  localparam int unsigned CW = $clog2(IDLE_CYCLES + 1);
  localparam logic [CW-1:0] IDLE_LIM = CW'(IDLE_CYCLES);

  logic [CW-1:0] idle_cnt;
  logic          idle_qual;

  assign idle_qual = (state_q == ST_RUN) && core_sleep_req && !access_req;

  always_ff @(posedge clk) begin
    if (rst)                    idle_cnt <= '0;
    else if (!idle_qual)        idle_cnt <= '0;
    else if (idle_cnt != IDLE_LIM) idle_cnt <= idle_cnt + CW'(1);
  end

  always_comb begin
    state_nx = state_q;
    unique case (state_q)
      ST_OFF:   if (init_done) state_nx = ST_WAKE;
      ST_WAKE: begin
        if (!init_done)   state_nx = ST_OFF;
        else if (pwr_ack) state_nx = ST_RUN;
      end
      ST_RUN: begin
        if (!init_done)   state_nx = ST_DRAIN;
        else if (!pwr_ack) state_nx = ST_FAULT;
        else if (idle_qual && (idle_cnt == IDLE_LIM)) state_nx = ST_DRAIN;
      end
      ST_DRAIN: if (!pwr_ack) state_nx = init_done ? ST_DOZE : ST_OFF;
      ST_DOZE: begin
        if (!init_done)      state_nx = ST_OFF;
        else if (access_req) state_nx = ST_WAKE;
      end
      ST_FAULT: if (!init_done) state_nx = ST_OFF;
      default:  state_nx = ST_OFF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_OFF;
    else     state_q <= state_nx;
  end

  assign clk_ready   = (state_q == ST_RUN);
  assign going_sleep = (state_q == ST_DRAIN);
  assign pwr_on      = (state_q == ST_WAKE) || (state_q == ST_RUN);

  always_comb begin
    unique case (state_q)
      ST_DOZE:  ps_type = PS_MAC;
      ST_FAULT: ps_type = PS_ERR;
      ST_RUN:   ps_type = rf_kill ? PS_PHY : PS_NONE;
      default:  ps_type = PS_NONE;
    endcase
  end

  // R3
  ready_needs_init_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(clk_ready) |-> $past(init_done));

  // R5
  sleep_refused_chk: assert property (@(posedge clk) disable iff (rst)
    (clk_ready && access_req && init_done && pwr_ack) |=> !going_sleep);

  // R6
  sleep_entry_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(going_sleep) |-> $past(!access_req || !init_done));

endmodule

// File: rtl/pwr_wake_ctrl.sv
module pwr_wake_ctrl
  import pwr_wake_pkg::*;
#(
  parameter int unsigned IDLE_CYCLES = 16,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned ADDR_W      = 2,
  parameter int unsigned DATA_W      = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              core_sleep_req,
  input  logic              pwr_ack,
  input  logic              rfkill_sw,
  output logic              pwr_on,
  output logic              host_grant,
  output logic              rfkill_irq,
  output logic              mstr_halt
);

  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(ADDR_CTRL);
  localparam logic [ADDR_W-1:0] A_RST  = ADDR_W'(ADDR_RST);
  localparam logic [ADDR_W-1:0] A_IRQ  = ADDR_W'(ADDR_IRQ);

  logic sw_rst_q, blk_rst;
  logic init_q, acc_q, stop_q, mdis_q;
  logic wr_ctrl, wr_rst, wr_irq, acc_nx;
  logic clk_ready, going_sleep, rf_state, irq_clr;
  logic [PS_W-1:0] ps_type;
  pwr_state_e st_q, st_nx;
  logic [DATA_W-1:0] rd_nx;
  logic wdata_unused;

  assign wdata_unused = ^reg_wdata;
  assign blk_rst = rst | sw_rst_q;
  assign wr_ctrl = reg_wr && (reg_addr == A_CTRL);
  assign wr_rst  = reg_wr && (reg_addr == A_RST);
  assign wr_irq  = reg_wr && (reg_addr == A_IRQ);
  assign irq_clr = wr_irq && reg_wdata[B_RFK_IRQ];
  assign acc_nx  = wr_ctrl ? reg_wdata[B_ACC] : acc_q;

  // one-cycle software reset pulse
  always_ff @(posedge clk) begin
    if (rst) sw_rst_q <= 1'b0;
    else     sw_rst_q <= !sw_rst_q && wr_rst && reg_wdata[B_SWRST];
  end

  always_ff @(posedge clk) begin
    if (blk_rst) begin
      init_q     <= 1'b0;
      acc_q      <= 1'b0;
      stop_q     <= 1'b0;
      mdis_q     <= 1'b0;
      host_grant <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        init_q <= reg_wdata[B_INIT];
        acc_q  <= reg_wdata[B_ACC];
      end
      if (wr_rst) stop_q <= reg_wdata[B_MSTOP];
      mdis_q     <= stop_q;
      host_grant <= acc_nx && (st_nx == ST_RUN);
    end
  end

  pwr_wake_fsm #(.IDLE_CYCLES(IDLE_CYCLES)) u_fsm (
    .clk           (clk),
    .rst           (blk_rst),
    .init_done     (init_q),
    .access_req    (acc_q),
    .core_sleep_req(core_sleep_req),
    .pwr_ack       (pwr_ack),
    .rf_kill       (rf_state),
    .state_q       (st_q),
    .state_nx      (st_nx),
    .clk_ready     (clk_ready),
    .going_sleep   (going_sleep),
    .pwr_on        (pwr_on),
    .ps_type       (ps_type)
  );

  pwr_rfkill_mon #(.SYNC_STAGES(SYNC_STAGES)) u_rfk (
    .clk      (clk),
    .rst      (blk_rst),
    .rfkill_sw(rfkill_sw),
    .irq_clr  (irq_clr),
    .rf_state (rf_state),
    .irq_pend (rfkill_irq)
  );

  always_comb begin
    rd_nx = '0;
    case (reg_addr)
      A_CTRL: begin
        rd_nx[B_CLK_RDY]        = clk_ready;
        rd_nx[B_INIT]           = init_q;
        rd_nx[B_ACC]            = acc_q;
        rd_nx[B_SLEEPING]       = going_sleep;
        rd_nx[B_PS_LO +: PS_W]  = ps_type;
        rd_nx[B_RFKILL]         = rf_state;
      end
      A_RST: begin
        rd_nx[B_MDIS]  = mdis_q;
        rd_nx[B_MSTOP] = stop_q;
      end
      A_IRQ: rd_nx[B_RFK_IRQ] = rfkill_irq;
      default: rd_nx = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (blk_rst) reg_rdata <= '0;
    else         reg_rdata <= rd_nx;
  end

  assign mstr_halt = stop_q;

  // R4
  grant_ready_chk: assert property (@(posedge clk) disable iff (blk_rst)
    host_grant |-> (clk_ready && !going_sleep && acc_q));

  // R12
  mdis_follow_chk: assert property (@(posedge clk) disable iff (blk_rst)
    $rose(stop_q) |=> mdis_q);

  // R13
  swrst_clear_chk: assert property (@(posedge clk) disable iff (rst)
    sw_rst_q |=> (!sw_rst_q && !init_q && !acc_q && !stop_q && !pwr_on && !host_grant));

  // R2
  off_without_init_chk: assert property (@(posedge clk) disable iff (blk_rst)
    (!init_q && !pwr_on) |=> !pwr_on);

endmodule

// File: tb/pwr_wake_ctrl_bench.sv
module pwr_wake_ctrl_bench;

  localparam int IDLE = 16;
  localparam int AW   = 2;
  localparam int DW   = 32;
  localparam int ACK_DLY = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          reg_wr = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;
  logic          core_sleep_req = 1'b0;
  logic          pwr_ack;
  logic          rfkill_sw = 1'b0;
  logic          pwr_on, host_grant, rfkill_irq, mstr_halt;
  logic          drop = 1'b0;
  logic [ACK_DLY-1:0] ack_sh = '0;

  int n_vec = 0;
  int n_bad = 0;
  logic mon_go = 1'b0;

  typedef struct {
    logic [DW-1:0] exp;
    logic [DW-1:0] mask;
    string         tag;
  } exp_t;
  exp_t sb_q[$];

  always #4 clk = ~clk;

  // analog power switch model: acknowledge follows enable after ACK_DLY cycles
  always @(posedge clk) ack_sh <= {ack_sh[ACK_DLY-2:0], pwr_on};
  assign pwr_ack = ack_sh[ACK_DLY-1] & ~drop;

  pwr_wake_ctrl #(.IDLE_CYCLES(IDLE)) u_pwr_wake_ctrl (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .core_sleep_req(core_sleep_req), .pwr_ack(pwr_ack), .rfkill_sw(rfkill_sw),
    .pwr_on(pwr_on), .host_grant(host_grant), .rfkill_irq(rfkill_irq),
    .mstr_halt(mstr_halt)
  );

  // monitor: compares read data against queued expectations
  always @(negedge clk) begin
    exp_t it;
    if (mon_go && sb_q.size() > 0) begin
      it = sb_q.pop_front();
      n_vec++;
      if ((reg_rdata & it.mask) !== (it.exp & it.mask)) begin
        n_bad++;
        $display("FAIL %s: rdata=%h expected=%h (mask %h)", it.tag,
                 reg_rdata & it.mask, it.exp & it.mask, it.mask);
      end
    end
  end

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(posedge clk); #1;
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd_exp(input logic [AW-1:0] a, input logic [DW-1:0] e,
                        input logic [DW-1:0] m, input string tag);
    @(posedge clk); #1;
    reg_addr = a;
    sb_q.push_back('{exp: e, mask: m, tag: tag});
    @(posedge clk); #1;
    mon_go = 1'b1;
    @(posedge clk); #1;
    mon_go = 1'b0;
  endtask

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] e);
    n_vec++;
    if (act !== e) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, e);
    end
  endtask

  task automatic poll(input logic [DW-1:0] m, input logic [DW-1:0] v,
                      input int lim, output logic hit);
    hit = 1'b0;
    @(posedge clk); #1;
    reg_addr = AW'(0);
    @(posedge clk);
    for (int i = 0; i < lim; i++) begin
      @(negedge clk);
      if ((reg_rdata & m) == v) begin
        hit = 1'b1;
        break;
      end
    end
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin
    logic hit;
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;

    // R1 reset state
    rd_exp(2'd0, 32'h0, 32'hFFFF_FFFF, "R1 ctrl after reset");
    @(negedge clk);
    chk("R1 pwr_on after reset", 32'(pwr_on), 32'h0);
    chk("R1 grant after reset", 32'(host_grant), 32'h0);

    // R2 access request without init done keeps the domain off
    wr(2'd0, 32'h8);
    repeat (20) @(posedge clk);
    @(negedge clk);
    chk("R2 pwr_on without init", 32'(pwr_on), 32'h0);
    chk("R4 grant without ready", 32'(host_grant), 32'h0);
    rd_exp(2'd0, 32'h8, 32'hFFFF_FFFF, "R2 ctrl without init");

    // R3 init done brings the core up
    wr(2'd0, 32'hC);
    poll(32'h1, 32'h1, 60, hit);
    chk("R3 clock-ready reached", 32'(hit), 32'h1);
    rd_exp(2'd0, 32'hD, 32'hFFFF_FFFF, "R3 ctrl when ready");
    @(negedge clk);
    chk("R4 grant when ready", 32'(host_grant), 32'h1);
    chk("R3 pwr_on when ready", 32'(pwr_on), 32'h1);

    // R5 sleep request refused while access held
    core_sleep_req = 1'b1;
    repeat (IDLE * 3) @(posedge clk);
    rd_exp(2'd0, 32'hD, 32'hFFFF_FFFF, "R5 still ready under sleep request");
    @(negedge clk);
    chk("R5 grant kept", 32'(host_grant), 32'h1);

    // R8 / R9 / R10 RF-kill switch
    rfkill_sw = 1'b1;
    poll(32'h0800_0000, 32'h0800_0000, 20, hit);
    chk("R8 switch mirrored", 32'(hit), 32'h1);
    rd_exp(2'd0, 32'h0A00_000D, 32'hFFFF_FFFF, "R8 ctrl with switch active");
    rd_exp(2'd2, 32'h80, 32'hFFFF_FFFF, "R9 pending after rise");
    @(negedge clk);
    chk("R9 irq output", 32'(rfkill_irq), 32'h1);
    wr(2'd2, 32'h0);
    rd_exp(2'd2, 32'h80, 32'hFFFF_FFFF, "R10 write 0 keeps pending");
    wr(2'd2, 32'h80);
    rd_exp(2'd2, 32'h0, 32'hFFFF_FFFF, "R10 write 1 clears");
    @(negedge clk);
    chk("R10 irq output cleared", 32'(rfkill_irq), 32'h0);
    rfkill_sw = 1'b0;
    poll(32'h0800_0000, 32'h0, 20, hit);
    chk("R8 switch release mirrored", 32'(hit), 32'h1);
    rd_exp(2'd2, 32'h80, 32'hFFFF_FFFF, "R9 pending after fall");
    wr(2'd2, 32'h80);

    // R6 / R7 release access: idle timeout then doze
    wr(2'd0, 32'h4);
    repeat (IDLE - 6) @(posedge clk);
    rd_exp(2'd0, 32'h1, 32'h11, "R6 still ready before idle limit");
    poll(32'h11, 32'h10, 60, hit);
    chk("R6 going-to-sleep seen", 32'(hit), 32'h1);
    chk("R6 pwr_on off while draining", 32'(pwr_on), 32'h0);
    poll(32'h0700_0011, 32'h0100_0000, 60, hit);
    chk("R7 MAC power-down type", 32'(hit), 32'h1);
    chk("R7 pwr_on off in doze", 32'(pwr_on), 32'h0);
    chk("R4 no grant in doze", 32'(host_grant), 32'h0);

    // R7 wake on access request
    core_sleep_req = 1'b0;
    wr(2'd0, 32'hC);
    poll(32'h1, 32'h1, 60, hit);
    chk("R7 woke to ready", 32'(hit), 32'h1);
    rd_exp(2'd0, 32'hD, 32'h0700_001D, "R7 ctrl after wake");
    @(negedge clk);
    chk("R4 grant after wake", 32'(host_grant), 32'h1);

    // R12 bus-master stop
    wr(2'd1, 32'h200);
    rd_exp(2'd1, 32'h300, 32'hFFFF_FFFF, "R12 stop and disabled");
    @(negedge clk);
    chk("R12 mstr_halt", 32'(mstr_halt), 32'h1);

    // R11 power acknowledge lost while ready
    drop = 1'b1;
    poll(32'h0700_0000, 32'h0300_0000, 20, hit);
    chk("R11 error type", 32'(hit), 32'h1);
    rd_exp(2'd0, 32'h0300_0000, 32'h0700_0011, "R11 ctrl in fault");
    @(negedge clk);
    chk("R11 grant dropped", 32'(host_grant), 32'h0);
    chk("R11 pwr_on dropped", 32'(pwr_on), 32'h0);

    // R13 software reset
    wr(2'd1, 32'h80);
    drop = 1'b0;
    rd_exp(2'd0, 32'h0, 32'hFFFF_FFFF, "R13 ctrl after sw reset");
    rd_exp(2'd1, 32'h0, 32'hFFFF_FFFF, "R13 reset reg after sw reset");
    rd_exp(2'd2, 32'h0, 32'hFFFF_FFFF, "R13 irq reg after sw reset");
    @(negedge clk);
    chk("R13 pwr_on after sw reset", 32'(pwr_on), 32'h0);
    chk("R13 mstr_halt after sw reset", 32'(mstr_halt), 32'h0);
    chk("R13 grant after sw reset", 32'(host_grant), 32'h0);

    repeat (4) @(posedge clk);
    summary();
    $finish;
  end

endmodule